// File: doc/BRIEF.md
# Retriggerable Interrupt Aggregator

This block merges eight active-high, level-held bus interrupt requests into one interrupt line. That line is meant for an edge-sensitive processor input. Every request passes through a synchronizer first. It then sets a pending bit in a status register that software can read. The output is high while any pending bit is set. It returns low without help once nothing is pending.

A control register selects one of two status behaviours:

- **Latched mode:** a pending bit is captured on the rising edge of its request. Software clears it by writing a 1 to it.
- **Auto-clear mode:** each pending bit simply follows its synchronized request.

A source can raise a new request while the previous one is being serviced. In that case the line never falls, and an edge-triggered input would see nothing. To cover this, software sets a retrigger bit after each service pass. The block then holds the line low for a fixed number of clocks. After that interval it raises the line again if anything is still pending, which gives the processor a fresh rising edge.

Top module: `retrig_irq_merge`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00 and `irqOut` is 0.
- R2: Status bit i (read with `regSel`=0) reflects `reqIn[i]`. The bit order, from bit 0 to bit 7, is the lowest-priority source to the highest-priority source.
- R3: In latched mode (control bit 1 = 0), a rising edge on a request sets its status bit. The bit stays set after the request returns to 0.
- R4: In latched mode, writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. A rising edge that reaches a bit in the same cycle as its clear wins, so the bit stays set.
- R5: Writing control bit 1 = 1 selects auto-clear mode, and the control register reads this bit back at bit 1. In this mode each status bit equals its synchronized request, so it clears with no write once the source drops.
- R6: `irqOut` is 1 one clock after any status bit is set, provided no retrigger interval is running. It is 0 one clock after all status bits are clear.
- R7: Writing control bit 0 = 1 forces `irqOut` low for exactly RETRIG_CYCLES clocks. After that, `irqOut` goes high again if any status bit is set.
- R8: Control bit 0 reads 1 while the retrigger interval runs and reads 0 once it ends. Requests that change during the interval do not shorten it. With nothing pending, `irqOut` stays 0 throughout and afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 8 | Level interrupt requests, bit 0 lowest priority |
| regSel | input | 1 | Register select: 0 status, 1 control |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register (combinational) |
| irqOut | output | 1 | Aggregate interrupt line to the processor |

## Verification
The hardest case to reach is a write-clear that lands on the same clock edge as a fresh rising edge of the same source. The bench gets there by raising the request and waiting exactly the two synchronizer clocks. It then issues the status write, so both arrive at the status flop together, and it expects the bit to survive. A second hard case is a request that drops while another rises inside a retrigger interval. The bench counts low cycles on `irqOut` while changing `reqIn` mid-interval. This shows that the interval length is fixed and that the line rises again for the new source.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Number of merged request sources; also the register data width.
  localparam int SRC_N = 8;

  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic [SRC_N-1:0] clrMask;   // status bits to clear this cycle
    logic             autoClr;   // status follows synchronized sources
    logic             holdLow;   // retrigger interval in progress
  } ctrl_stb_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int RETRIG_CYCLES = 37
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [SRC_N-1:0] wrData,
  output ctrl_stb_t        stb,
  output logic [SRC_N-1:0] ctrlRd
);
  localparam int CNT_W = $clog2(RETRIG_CYCLES + 1);

  logic             autoClrQ;
  logic             holdQ;
  logic [CNT_W-1:0] cntQ;
  logic             ctrlWr;
  logic             statWr;

  assign ctrlWr = wrEn && regSel;
  assign statWr = wrEn && !regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoClrQ <= 1'b0;
      holdQ    <= 1'b0;
      cntQ     <= '0;
    end else begin
      if (ctrlWr) autoClrQ <= wrData[1];
      if (holdQ) begin
        // fixed interval: only the counter ends it
        if (cntQ == '0) holdQ <= 1'b0;
        else            cntQ  <= cntQ - CNT_W'(1);
      end else if (ctrlWr && wrData[0]) begin
        holdQ <= 1'b1;
        cntQ  <= CNT_W'(RETRIG_CYCLES - 1);
      end
    end
  end

  always_comb begin
    stb.clrMask = statWr ? wrData : '0;
    stb.autoClr = autoClrQ;
    stb.holdLow = holdQ;
    ctrlRd      = '0;
    ctrlRd[1]   = autoClrQ;
    ctrlRd[0]   = holdQ;
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] reqIn,
  input  ctrl_stb_t        stb,
  output logic [SRC_N-1:0] statusVec,
  output logic             irqOut
);
  logic [SRC_N-1:0] syncQ [SYNC_STAGES];
  logic [SRC_N-1:0] reqS;
  logic [SRC_N-1:0] prevQ;
  logic [SRC_N-1:0] riseVec;
  logic             irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= reqIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= reqS;
    end
  end

  assign reqS    = syncQ[SYNC_STAGES-1];
  assign riseVec = reqS & ~prevQ;

  for (genvar b = 0; b < SRC_N; b++) begin : g_stat
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              bitQ <= 1'b0;
      else if (stb.autoClr)   bitQ <= reqS[b];
      else if (riseVec[b])    bitQ <= 1'b1;   // set beats clear
      else if (stb.clrMask[b]) bitQ <= 1'b0;
    end
    assign statusVec[b] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= (|statusVec) && !stb.holdLow;
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/retrig_irq_merge.sv
module retrig_irq_merge
  import irq_agg_pkg::*;
#(
  parameter int RETRIG_CYCLES = 37,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] reqIn,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [SRC_N-1:0] wrData,
  output logic [SRC_N-1:0] rdData,
  output logic             irqOut
);
  ctrl_stb_t        ctrlStb;
  logic [SRC_N-1:0] ctrlRd;
  logic [SRC_N-1:0] statusVec;

  irq_agg_ctrl #(.RETRIG_CYCLES(RETRIG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .stb(ctrlStb), .ctrlRd(ctrlRd)
  );

  irq_agg_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .stb(ctrlStb),
    .statusVec(statusVec), .irqOut(irqOut)
  );

  assign rdData = regSel ? ctrlRd : statusVec;
endmodule

// File: rtl/retrig_irq_merge_chk.sv
module retrig_irq_merge_chk
  import irq_agg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regSel,
  input logic             wrEn,
  input logic [SRC_N-1:0] wrData,
  input logic             irqOut,
  input logic [SRC_N-1:0] statusVec,
  input logic             holdLow,
  input logic             autoClr
);
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusVec == '0) |-> !irqOut);

  p_pending_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusVec != '0 && !holdLow) |-> irqOut);

  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdLow) |-> !irqOut);

  p_retrig_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdLow) |-> $past(wrEn && regSel && wrData[0]));

  p_latch_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!autoClr && !(wrEn && !regSel))
      |-> ((statusVec & $past(statusVec)) == $past(statusVec)));
endmodule

bind retrig_irq_merge retrig_irq_merge_chk u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
  .irqOut(irqOut), .statusVec(statusVec),
  .holdLow(ctrlStb.holdLow), .autoClr(ctrlStb.autoClr)
);

// File: tb/retrig_irq_merge_tb.sv
module retrig_irq_merge_tb;
  localparam int RETRIG = 37;

  typedef struct {
    int    kind;   // 0 status read, 1 control read, 2 irq line
    int    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqIn = '0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic       rdSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       regSel;
  logic [7:0] rdData;
  logic       irqOut;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sbQ[$];

  assign regSel = wrEn ? wrSel : rdSel;

  retrig_irq_merge #(.RETRIG_CYCLES(RETRIG)) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare queued expectations one clock after they are posted
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        int act;
        it = sbQ.pop_front();
        rdSel = (it.kind == 1);
        #1;
        act = (it.kind == 2) ? int'(irqOut) : int'(rdData);
        check(act == it.exp, it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    cyc(1);
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    wrSel = sel; wrData = data; wrEn = 1'b1;
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic countLow(output int cnt, output bit sawHigh, input bit swapMid);
    cnt = 0; sawHigh = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!irqOut) begin
        cnt++;
        if (swapMid && cnt == 5) reqIn = 8'h08;
      end else if (cnt > 0) begin
        sawHigh = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    int  cnt;
    bit  hi;
    cyc(3);
    rstN = 1'b1;
    // R1 reset state
    push(0, 8'h00, "R1 status");
    push(1, 8'h00, "R1 control");
    push(2, 0, "R1 irq");

    // R2 bit mapping in latched mode
    for (int b = 0; b < 8; b++) begin
      reqIn = 8'(1 << b);
      cyc(4);
      push(0, 1 << b, "R2 map");
      if (b == 7) push(2, 1, "R6 irq high");
      reqIn = '0;
      writeReg(1'b0, 8'hFF);
      cyc(2);
    end

    // R3 latch holds after request drops
    reqIn = 8'h21;
    cyc(4);
    reqIn = '0;
    cyc(4);
    push(0, 8'h21, "R3 latched");
    push(2, 1, "R6 irq pending");

    // R4 selective clear
    writeReg(1'b0, 8'h01);
    push(0, 8'h20, "R4 clear one");
    // R4 rising edge and clear reach the bit on the same edge
    reqIn = 8'h04;
    cyc(2);
    writeReg(1'b0, 8'h04);
    push(0, 8'h24, "R4 set wins");
    writeReg(1'b0, 8'h24);
    push(0, 8'h00, "R4 clear all");
    push(2, 0, "R6 irq idle");
    reqIn = '0;
    cyc(4);

    // R5 auto-clear mode
    writeReg(1'b1, 8'h02);
    push(1, 8'h02, "R5 ctrl readback");
    reqIn = 8'h81;
    cyc(4);
    push(0, 8'h81, "R5 follow");
    push(2, 1, "R6 irq high auto");
    reqIn = 8'h80;
    cyc(4);
    push(0, 8'h80, "R5 auto drop");
    reqIn = '0;
    cyc(4);
    push(0, 8'h00, "R5 auto empty");
    push(2, 0, "R6 irq low auto");

    // R7 retrigger with a request pending
    reqIn = 8'h10;
    cyc(5);
    writeReg(1'b1, 8'h03);
    countLow(cnt, hi, 1'b0);
    check(cnt == RETRIG, "R7 low length", cnt, RETRIG);
    check(hi, "R7 rise again", int'(hi), 1);

    // R8 requests change inside the interval
    writeReg(1'b1, 8'h03);
    countLow(cnt, hi, 1'b1);
    check(cnt == RETRIG, "R8 not shortened", cnt, RETRIG);
    check(hi, "R7 rise for new source", int'(hi), 1);

    // R8 retrigger with nothing pending
    reqIn = '0;
    cyc(5);
    writeReg(1'b1, 8'h03);
    push(1, 8'h03, "R8 busy reads 1");
    cyc(5);
    push(2, 0, "R8 idle stays low");
    cyc(RETRIG);
    push(1, 8'h02, "R8 self clear");
    push(2, 0, "R8 idle after");

    cyc(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule